// File: doc/BRIEF.md
# Double-Buffered DAC Register Controller

This block keeps the digital register state of a multi-channel DAC. Each channel has two stages. A staging (input) stage receives new values. A live (active) stage drives the converter. Each stage holds an 18-bit output code and a 4-bit range selector. Commands reach the block already decoded. Four kinds are supported:

- store a code into staging;
- store a range into staging;
- promote staging to live for the addressed channels;
- store a code and promote it in one step.

A falling edge on the load strobe promotes every channel. This works only while no instruction is open.

The active-low clear input passes through a two-flop synchronizer. While it is asserted, it forces every live stage to zero and leaves the staging registers untouched, so a later promote brings back the earlier output. A clear that arrives while an instruction is open aborts that instruction. The block then raises a sticky per-channel suspect bit for the channels the aborted write was aimed at. The active-low integrity flag drops on reset, on clear and on a supply brownout. It stays low until a valid promote completes.

A range-override mode can be enabled. In that mode, each promote loads a strapped range value in place of the staged range, so range and code change in the same cycle.

Top module: `dac_dbuf_ctrl`

## Requirements
- R1: After reset, every live code and range is 0 (range 0 is the unipolar 0 to 5 V span), the integrity flag is low and every suspect bit is 0.
- R2: A code store (op 1) or range store (op 2, range taken from data bits [3:0]) changes only the staging stage; live outputs keep their values.
- R3: A promote (op 3) copies staging to live for the addressed channel. Address 15 selects every channel, addresses 0 and 1 select one channel each, and any other address changes nothing.
- R4: A store-and-promote (op 4) puts the new code on the live output of the addressed channel, together with its staged range, on the clock edge that accepts the command.
- R5: While range override is enabled, a promote loads the strapped range into the live range instead of the staged range.
- R6: Two edges after the clear input goes low, the next edge zeroes every live code and range, and they stay zero while clear is held. Staging is kept, so a later promote restores it.
- R7: If clear is seen while an instruction is open, any command that instruction completes is discarded, even after clear is released, until the instruction closes.
- R8: An aborted write (op 1, 2 or 4) sets the suspect bit of each channel it targeted. The bit stays set until a completed store to that channel.
- R9: A falling edge of the load strobe with no instruction open promotes all channels. While an instruction is open, the edge is ignored.
- R10: The integrity flag is driven low by reset, by clear and by brownout. It returns high only on a valid promote (command or strobe) taken while neither clear nor brownout is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| cmd_valid | input | 1 | Decoded command completes this cycle |
| cmd_op | input | 3 | Operation: 1 store code, 2 store range, 3 promote, 4 store code and promote |
| cmd_addr | input | 4 | Channel address, 15 = all channels |
| cmd_data | input | 18 | Code, or range in bits [3:0] |
| instr_open | input | 1 | An instruction is in progress |
| clr_n | input | 1 | Clear, active low, asynchronous to clk |
| ldac_n | input | 1 | Load strobe, falling edge promotes all |
| brownout | input | 1 | Supply has fallen below the safe level |
| range_ovr | input | 1 | Range override mode enable |
| strap_range | input | 4 | Range used when override is enabled |
| dac_code | output | 36 | Live codes, channel 0 in the low bits |
| dac_range | output | 8 | Live ranges, channel 0 in the low bits |
| integrity_n | output | 1 | Low while data integrity is not assured |
| suspect | output | 2 | Per-channel staging suspect after an abort |

## Verification
A staging register that is corrupt stays hidden until the next promote or strobe, and then shows on dac_code one edge later. The bench therefore promotes after every clear and abort, and compares the restored codes with what was staged. A live stage that is wrongly loaded shows on the edge after the accepted command. A wrong flag or a failed clear shows on integrity_n or dac_code by the third edge after clr_n falls. An abort latch that fails to hold lets the withheld write appear on the edge that accepts it.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;
    localparam int CH_N   = 2;
    localparam int CODE_W = 18;
    localparam int SPAN_W = 4;
    localparam int ADDR_W = 4;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NOP     = 3'd0,
        OP_WR_CODE = 3'd1,
        OP_WR_SPAN = 3'd2,
        OP_UPDATE  = 3'd3,
        OP_WR_UPD  = 3'd4
    } op_e;
endpackage

// File: rtl/dacreg_clr_sync.sv
module dacreg_clr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n_i,
    output logic clr_active_o
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], clr_n_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign clr_active_o = ~sync_q[STAGES-1];
endmodule

// File: rtl/dacreg_decode.sv
module dacreg_decode
    import dacreg_pkg::*;
#(
    parameter int N_CH = CH_N,
    parameter int AW   = ADDR_W
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [AW-1:0]   addr_i,
    output logic [N_CH-1:0] tgt_mask_o,
    output logic [N_CH-1:0] wr_code_mask_o,
    output logic [N_CH-1:0] wr_span_mask_o,
    output logic [N_CH-1:0] upd_mask_o,
    output logic            is_write_o,
    output logic            upd_any_o
);
    localparam logic [AW-1:0] ALL_ADDR = '1;

    logic wr_code, wr_span, upd;

    always_comb begin
        wr_code    = 1'b0;
        wr_span    = 1'b0;
        upd        = 1'b0;
        is_write_o = 1'b0;
        case (op_e'(op_i))
            OP_WR_CODE: begin wr_code = 1'b1; is_write_o = 1'b1; end
            OP_WR_SPAN: begin wr_span = 1'b1; is_write_o = 1'b1; end
            OP_UPDATE:  begin upd = 1'b1; end
            OP_WR_UPD:  begin wr_code = 1'b1; upd = 1'b1; is_write_o = 1'b1; end
            default:    ;
        endcase
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_match
        assign tgt_mask_o[g] = (addr_i == ALL_ADDR) || (addr_i == AW'(g));
    end

    assign wr_code_mask_o = {N_CH{wr_code}} & tgt_mask_o;
    assign wr_span_mask_o = {N_CH{wr_span}} & tgt_mask_o;
    assign upd_mask_o     = {N_CH{upd}} & tgt_mask_o;
    assign upd_any_o      = |upd_mask_o;
endmodule

// File: rtl/dacreg_ctrl.sv
module dacreg_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_active_i,
    input  logic instr_open_i,
    input  logic cmd_valid_i,
    input  logic upd_any_i,
    input  logic ldac_n_i,
    input  logic brownout_i,
    output logic accept_o,
    output logic ldac_upd_o,
    output logic abort_set_o,
    output logic aborting_o,
    output logic flag_ok_o
);
    typedef struct packed {
        logic ldac_prev;
        logic abort;
        logic flag_ok;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  valid_upd;

    always_comb begin
        accept_o    = cmd_valid_i && !clr_active_i && !st_q.abort;
        ldac_upd_o  = st_q.ldac_prev && !ldac_n_i && !instr_open_i && !clr_active_i;
        abort_set_o = clr_active_i && instr_open_i;
        valid_upd   = (accept_o && upd_any_i) || ldac_upd_o;

        st_d           = st_q;
        st_d.ldac_prev = ldac_n_i;
        if (!instr_open_i)    st_d.abort = 1'b0;
        else if (abort_set_o) st_d.abort = 1'b1;

        if (clr_active_i || brownout_i) st_d.flag_ok = 1'b0;
        else if (valid_upd)             st_d.flag_ok = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ldac_prev <= 1'b1;
            st_q.abort     <= 1'b0;
            st_q.flag_ok   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign aborting_o = st_q.abort;
    assign flag_ok_o  = st_q.flag_ok;

    assert_brownout_drops_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        brownout_i |=> !st_q.flag_ok);

    assert_clear_drops_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_active_i |=> !st_q.flag_ok);

    assert_strobe_releases_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ldac_n_i) && !instr_open_i && !clr_active_i && !brownout_i) |=> st_q.flag_ok);
endmodule

// File: rtl/dacreg_channel.sv
module dacreg_channel #(
    parameter int CW = 18,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_active_i,
    input  logic          wr_code_i,
    input  logic          wr_span_i,
    input  logic          upd_i,
    input  logic [CW-1:0] data_i,
    input  logic          range_ovr_i,
    input  logic [SW-1:0] strap_i,
    input  logic          abort_hit_i,
    output logic [CW-1:0] act_code_o,
    output logic [SW-1:0] act_span_o,
    output logic          suspect_o
);
    typedef struct packed {
        logic [CW-1:0] in_code;
        logic [SW-1:0] in_span;
        logic [CW-1:0] act_code;
        logic [SW-1:0] act_span;
        logic          suspect;
    } chan_t;

    chan_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (wr_code_i) ch_d.in_code = data_i;
        if (wr_span_i) ch_d.in_span = data_i[SW-1:0];

        if (clr_active_i) begin
            ch_d.act_code = '0;
            ch_d.act_span = '0;
        end else if (upd_i) begin
            ch_d.act_code = ch_d.in_code;
            ch_d.act_span = range_ovr_i ? strap_i : ch_d.in_span;
        end

        if (abort_hit_i)              ch_d.suspect = 1'b1;
        else if (wr_code_i || wr_span_i) ch_d.suspect = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign act_code_o = ch_q.act_code;
    assign act_span_o = ch_q.act_span;
    assign suspect_o  = ch_q.suspect;

    assert_clear_zeroes_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_active_i |=> (ch_q.act_code == '0) && (ch_q.act_span == '0));

    assert_live_holds_without_promote_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_i && !clr_active_i) |=> ($stable(ch_q.act_code) && $stable(ch_q.act_span)));

    assert_suspect_only_from_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch_q.suspect) |-> $past(abort_hit_i));
endmodule

// File: rtl/dac_dbuf_ctrl.sv
module dac_dbuf_ctrl
    import dacreg_pkg::*;
#(
    parameter int N_CH       = CH_N,
    parameter int CW         = CODE_W,
    parameter int SW         = SPAN_W,
    parameter int AW         = ADDR_W,
    parameter int CLR_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [OP_W-1:0]    cmd_op,
    input  logic [AW-1:0]      cmd_addr,
    input  logic [CW-1:0]      cmd_data,
    input  logic               instr_open,
    input  logic               clr_n,
    input  logic               ldac_n,
    input  logic               brownout,
    input  logic               range_ovr,
    input  logic [SW-1:0]      strap_range,
    output logic [N_CH*CW-1:0] dac_code,
    output logic [N_CH*SW-1:0] dac_range,
    output logic               integrity_n,
    output logic [N_CH-1:0]    suspect
);
    logic            clr_active;
    logic [N_CH-1:0] tgt_mask, wr_code_mask, wr_span_mask, upd_mask;
    logic            is_write, upd_any;
    logic            accept, ldac_upd, abort_set, aborting, flag_ok;

    dacreg_clr_sync #(.STAGES(CLR_STAGES)) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_n_i      (clr_n),
        .clr_active_o (clr_active)
    );

    dacreg_decode #(.N_CH(N_CH), .AW(AW)) u_dec (
        .op_i           (cmd_op),
        .addr_i         (cmd_addr),
        .tgt_mask_o     (tgt_mask),
        .wr_code_mask_o (wr_code_mask),
        .wr_span_mask_o (wr_span_mask),
        .upd_mask_o     (upd_mask),
        .is_write_o     (is_write),
        .upd_any_o      (upd_any)
    );

    dacreg_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_active_i (clr_active),
        .instr_open_i (instr_open),
        .cmd_valid_i  (cmd_valid),
        .upd_any_i    (upd_any),
        .ldac_n_i     (ldac_n),
        .brownout_i   (brownout),
        .accept_o     (accept),
        .ldac_upd_o   (ldac_upd),
        .abort_set_o  (abort_set),
        .aborting_o   (aborting),
        .flag_ok_o    (flag_ok)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        dacreg_channel #(.CW(CW), .SW(SW)) u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .clr_active_i (clr_active),
            .wr_code_i    (accept && wr_code_mask[g]),
            .wr_span_i    (accept && wr_span_mask[g]),
            .upd_i        ((accept && upd_mask[g]) || ldac_upd),
            .data_i       (cmd_data),
            .range_ovr_i  (range_ovr),
            .strap_i      (strap_range),
            .abort_hit_i  (abort_set && is_write && tgt_mask[g]),
            .act_code_o   (dac_code[g*CW +: CW]),
            .act_span_o   (dac_range[g*SW +: SW]),
            .suspect_o    (suspect[g])
        );
    end

    assign integrity_n = flag_ok;

    assert_abort_blocks_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (aborting && instr_open) |=> ($stable(dac_code) && $stable(dac_range)));

    assert_strobe_ignored_in_instr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_open && !cmd_valid && !clr_active) |=> ($stable(dac_code) && $stable(dac_range)));
endmodule

// File: tb/dac_dbuf_ctrl_tb.sv
module dac_dbuf_ctrl_tb;
    localparam int CW = 18;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [3:0] cmd_addr = '0;
    logic [CW-1:0] cmd_data = '0;
    logic instr_open = 1'b0, clr_n = 1'b1, ldac_n = 1'b1, brownout = 1'b0, range_ovr = 1'b0;
    logic [SW-1:0] strap_range = '0;
    logic [2*CW-1:0] dac_code;
    logic [2*SW-1:0] dac_range;
    logic integrity_n;
    logic [1:0] suspect;

    int errors = 0, checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dac_dbuf_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .instr_open(instr_open),
        .clr_n(clr_n), .ldac_n(ldac_n), .brownout(brownout), .range_ovr(range_ovr),
        .strap_range(strap_range), .dac_code(dac_code), .dac_range(dac_range),
        .integrity_n(integrity_n), .suspect(suspect)
    );

    typedef struct packed {
        logic [2:0]    op;
        logic [3:0]    addr;
        logic [CW-1:0] data;
        logic [CW-1:0] c0;
        logic [CW-1:0] c1;
        logic [SW-1:0] s0;
        logic [SW-1:0] s1;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{3'd1, 4'd0,  18'h12345, 18'h0,     18'h0,     4'd0, 4'd0},  // R2 store code ch0
        '{3'd2, 4'd1,  18'h00003, 18'h0,     18'h0,     4'd0, 4'd0},  // R2 store range ch1
        '{3'd3, 4'd0,  18'h0,     18'h12345, 18'h0,     4'd0, 4'd0},  // R3 promote ch0
        '{3'd1, 4'd15, 18'h2AAAA, 18'h12345, 18'h0,     4'd0, 4'd0},  // R2 store all
        '{3'd3, 4'd15, 18'h0,     18'h2AAAA, 18'h2AAAA, 4'd0, 4'd3},  // R3 promote all
        '{3'd4, 4'd1,  18'h3FFFF, 18'h2AAAA, 18'h3FFFF, 4'd0, 4'd3},  // R4 store+promote ch1
        '{3'd3, 4'd5,  18'h0,     18'h2AAAA, 18'h3FFFF, 4'd0, 4'd3},  // R3 unmatched address
        '{3'd2, 4'd0,  18'h00007, 18'h2AAAA, 18'h3FFFF, 4'd0, 4'd3},  // R2 store range ch0
        '{3'd4, 4'd0,  18'h00001, 18'h00001, 18'h3FFFF, 4'd7, 4'd3}   // R4 store+promote ch0
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [3:0] addr, input logic [CW-1:0] data);
        instr_open = 1'b1; cmd_op = op; cmd_addr = addr; cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; instr_open = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_out(input string tag, input logic [CW-1:0] c0, input logic [CW-1:0] c1,
                           input logic [SW-1:0] s0, input logic [SW-1:0] s1);
        chk({tag, " code0"}, 32'(dac_code[CW-1:0]), 32'(c0));
        chk({tag, " code1"}, 32'(dac_code[2*CW-1:CW]), 32'(c1));
        chk({tag, " range0"}, 32'(dac_range[SW-1:0]), 32'(s0));
        chk({tag, " range1"}, 32'(dac_range[2*SW-1:SW]), 32'(s1));
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_out("R1 reset", 0, 0, 0, 0);
        chk("R1 flag after reset", 32'(integrity_n), 0);
        chk("R1 suspect after reset", 32'(suspect), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i].op, VEC[i].addr, VEC[i].data);
            chk_out($sformatf("R2/R3/R4 vector %0d", i), VEC[i].c0, VEC[i].c1, VEC[i].s0, VEC[i].s1);
        end
        chk("R10 flag released by promote", 32'(integrity_n), 1);

        // R5 range override
        range_ovr = 1'b1; strap_range = 4'd9;
        issue(3'd3, 4'd15, '0);
        chk_out("R5 override", 18'h00001, 18'h3FFFF, 4'd9, 4'd9);
        range_ovr = 1'b0;

        // R6 clear zeroes live, keeps staging
        clr_n = 1'b0;
        repeat (4) @(negedge clk);
        chk_out("R6 cleared", 0, 0, 0, 0);
        chk("R10 flag on clear", 32'(integrity_n), 0);
        clr_n = 1'b1;
        repeat (4) @(negedge clk);
        chk_out("R6 stays zero", 0, 0, 0, 0);

        // R9 strobe promotes all
        ldac_n = 1'b0;
        @(negedge clk);
        ldac_n = 1'b1;
        @(negedge clk);
        chk_out("R6 R9 strobe restore", 18'h00001, 18'h3FFFF, 4'd7, 4'd3);
        chk("R9 flag after strobe", 32'(integrity_n), 1);

        // R9 strobe ignored inside instruction
        issue(3'd1, 4'd0, 18'h0ABCD);
        instr_open = 1'b1;
        @(negedge clk);
        ldac_n = 1'b0;
        @(negedge clk);
        ldac_n = 1'b1;
        @(negedge clk);
        instr_open = 1'b0;
        @(negedge clk);
        chk("R9 strobe ignored", 32'(dac_code[CW-1:0]), 32'h00001);

        // R7 R8 abort
        instr_open = 1'b1; cmd_op = 3'd1; cmd_addr = 4'd1; cmd_data = 18'h11111;
        @(negedge clk);
        clr_n = 1'b0;
        repeat (4) @(negedge clk);
        clr_n = 1'b1;
        repeat (4) @(negedge clk);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; instr_open = 1'b0;
        @(negedge clk);
        chk("R8 suspect set", 32'(suspect), 32'b10);
        chk("R7 no commit", 32'(dac_code[2*CW-1:CW]), 0);
        issue(3'd3, 4'd15, '0);
        chk("R7 aborted write dropped", 32'(dac_code[2*CW-1:CW]), 32'h3FFFF);
        chk("R6 staged code restored", 32'(dac_code[CW-1:0]), 32'h0ABCD);
        issue(3'd1, 4'd1, 18'h22222);
        chk("R8 suspect cleared", 32'(suspect), 0);

        // R10 brownout
        brownout = 1'b1;
        @(negedge clk);
        chk("R10 flag on brownout", 32'(integrity_n), 0);
        issue(3'd3, 4'd15, '0);
        chk("R10 promote during brownout", 32'(integrity_n), 0);
        brownout = 1'b0;
        @(negedge clk);
        chk("R10 flag held low", 32'(integrity_n), 0);
        issue(3'd3, 4'd1, '0);
        chk("R10 flag released", 32'(integrity_n), 1);
        chk("R3 promote ch1", 32'(dac_code[2*CW-1:CW]), 32'h22222);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule